// File: doc/BRIEF.md
# Watermark Pause Frame Flow Controller

This block decides when a full-duplex Ethernet MAC should send pause frames. It watches the free space left in the receive buffer. When space falls under a high watermark, it asks the transmitter for a pause with the largest time. Once space has grown past a low watermark, and only if that largest pause was sent first, it asks for a pause with time zero. This zero-time pause releases the link partner. The gap between the two watermarks gives hysteresis, so the block does not keep switching between the two kinds of pause.

Software can also ask for either kind of pause directly by setting a bit in the control register. Each such bit clears itself once the transmitter reports that the frame has gone out. The block also tracks pause frames received from the link partner. It keeps a sticky flag for them that clears when read, shows a live status bit, and drives a hold signal that stops the local transmitter when flow control is enabled.

Only one request is outstanding at a time, and it is held until the transmitter acknowledges it. Building and parsing the frames themselves is done elsewhere.

Top module: `pause_wm_ctrl`

## Requirements
- R1: After reset, `pause_req` is 0. The control register (select 0) reads 8'h00. The threshold register (select 1) reads 8'h83, which is high watermark 3 in bits [3:0] and low watermark 8 in bits [7:4], both in 1024-byte units.
- R2: When the automatic enable (control bit 0) is set and the block is watching, a free space below high×1024 bytes causes a request with `pause_time` 16'hFFFF. The request appears one clock edge after the condition holds.
- R3: A request with time 16'h0000 is raised automatically only after an automatic 16'hFFFF pause has been acknowledged, and only while free space is above low×1024 bytes. Free space between the two watermarks raises nothing.
- R4: When automatic enable is 0, free space never causes a request.
- R5: A high watermark of 0 never causes an automatic request, even with zero free space.
- R6: An outstanding request keeps `pause_req` high and `pause_time` stable until `pause_ack` is seen. `pause_req` goes low the cycle after that.
- R7: Control bit 2 requests a pause with time 16'h0000 and control bit 3 requests a pause with time 16'hFFFF. Writing 1 to either bit sets it and writing 0 has no effect. Each bit clears when its own request is acknowledged.
- R8: Manual requests win over automatic ones, and a manual 16'hFFFF request wins over a manual 16'h0000 request.
- R9: A `rx_pause_rcvd` pulse sets control bit 4, and reading the control register clears that bit. Control bit 5 shows `rx_pause_active` live. `tx_hold` is high exactly when control bit 1 (flow-control enable) is set and `rx_pause_active` is high.
- R10: Once the release pause is acknowledged, the block goes back to watching, and a new fall below the high watermark raises another 16'hFFFF request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_bytes | input | 15 | Receive buffer free space in bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects of reading) |
| reg_sel | input | 1 | Register select: 0 control, 1 thresholds |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| pause_req | output | 1 | Pause frame request to the transmitter |
| pause_time | output | 16 | Pause time carried by the request |
| pause_ack | input | 1 | Transmitter finished the requested frame |
| rx_pause_rcvd | input | 1 | Pulse: pause frame received |
| rx_pause_active | input | 1 | Live received-pause state |
| tx_hold | output | 1 | Stop local transmitter |

## Verification
The hardest case to reach is the one where a manual 16'hFFFF request, a manual 16'h0000 request and an automatic high-water condition are all pending in the same cycle. To get there, the bench holds free space below the high watermark. It then sets the automatic enable and both manual bits in a single register write, so all three arrive at the arbiter on the same edge. It then acknowledges the requests one at a time and checks that they are served in the order manual 16'hFFFF, manual 16'h0000, automatic 16'hFFFF. After that, it checks that the hysteresis state was armed only by the automatic request.

// File: rtl/pwm_pkg.sv
// Package pwm_pkg
// Shared types and register field positions for the pause flow controller.
// Assumes an 8-bit register window with two registers.
package pwm_pkg;

    // Control register bit positions
    localparam int unsigned CB_AUTO_EN  = 0;
    localparam int unsigned CB_FC_EN    = 1;
    localparam int unsigned CB_MAN_ZERO = 2;
    localparam int unsigned CB_MAN_MAX  = 3;
    localparam int unsigned CB_RX_SEEN  = 4;
    localparam int unsigned CB_RX_LIVE  = 5;

    // Origin of the request currently held
    typedef enum logic [1:0] {
        SRC_MAN_MAX   = 2'd0,
        SRC_MAN_ZERO  = 2'd1,
        SRC_AUTO_MAX  = 2'd2,
        SRC_AUTO_ZERO = 2'd3
    } req_src_t;

    // Hysteresis state of the watermark logic
    typedef enum logic {
        WM_WATCH = 1'b0,
        WM_ARMED = 1'b1
    } wm_state_t;

endpackage

// File: rtl/pwm_thr_cmp.sv
// Module pwm_thr_cmp
// Compares a byte count against a threshold given in 2**UNIT_LOG2-byte units.
// ABOVE=0 flags count < threshold, ABOVE=1 flags count > threshold.
// Assumes purely combinational use; the caller registers the result.
module pwm_thr_cmp #(
    parameter int unsigned FREE_W    = 15,
    parameter int unsigned THR_W     = 4,
    parameter int unsigned UNIT_LOG2 = 10,
    parameter bit          ABOVE     = 1'b0
) (
    input  logic [FREE_W-1:0] count,
    input  logic [THR_W-1:0]  thr,
    output logic              hit
);
    localparam int unsigned TB_W  = THR_W + UNIT_LOG2;
    localparam int unsigned CMP_W = ((FREE_W > TB_W) ? FREE_W : TB_W) + 1;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] thr_ext;

    // Widen both operands to a common width
    always_comb begin
        cnt_ext = CMP_W'(count);
        thr_ext = CMP_W'({thr, {UNIT_LOG2{1'b0}}});
    end

    generate
        if (ABOVE) begin : g_above
            // Strictly greater than the threshold
            always_comb hit = (cnt_ext > thr_ext);
        end else begin : g_below
            // Strictly less than the threshold
            always_comb hit = (cnt_ext < thr_ext);
        end
    endgenerate
endmodule

// File: rtl/pwm_regs.sv
// Module pwm_regs
// Control and threshold registers. Manual pause bits are set by writing 1 and
// cleared by completion pulses. The received-pause flag is sticky and clears on
// a read of the control register. Assumes 2*THR_W <= 8.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned THR_W  = 4,
    parameter int unsigned HI_DEF = 3,
    parameter int unsigned LO_DEF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             done_man_max,
    input  logic             done_man_zero,
    input  logic             rx_pause_rcvd,
    input  logic             rx_pause_active,
    output logic             auto_en,
    output logic             fc_en,
    output logic             man_max_pend,
    output logic             man_zero_pend,
    output logic [THR_W-1:0] hi_thr,
    output logic [THR_W-1:0] lo_thr
);
    localparam int unsigned LO_POS = 4;

    logic wr_ctrl, wr_thr, rd_ctrl;
    logic rx_seen;

    // Decode register strobes
    always_comb begin
        wr_ctrl = reg_wr && !reg_sel;
        wr_thr  = reg_wr &&  reg_sel;
        rd_ctrl = reg_rd && !reg_sel;
    end

    // Enable bits follow writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en <= 1'b0;
            fc_en   <= 1'b0;
        end else if (wr_ctrl) begin
            auto_en <= reg_wdata[CB_AUTO_EN];
            fc_en   <= reg_wdata[CB_FC_EN];
        end
    end

    // Manual max pause bit: write-1 set, completion clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                  man_max_pend <= 1'b0;
        else if (wr_ctrl && reg_wdata[CB_MAN_MAX])   man_max_pend <= 1'b1;
        else if (done_man_max)                       man_max_pend <= 1'b0;
    end

    // Manual zero pause bit: write-1 set, completion clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                  man_zero_pend <= 1'b0;
        else if (wr_ctrl && reg_wdata[CB_MAN_ZERO])  man_zero_pend <= 1'b1;
        else if (done_man_zero)                      man_zero_pend <= 1'b0;
    end

    // Sticky received-pause flag, a new event wins over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n)             rx_seen <= 1'b0;
        else if (rx_pause_rcvd) rx_seen <= 1'b1;
        else if (rd_ctrl)       rx_seen <= 1'b0;
    end

    // Watermark thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_thr <= THR_W'(HI_DEF);
            lo_thr <= THR_W'(LO_DEF);
        end else if (wr_thr) begin
            hi_thr <= reg_wdata[THR_W-1:0];
            lo_thr <= reg_wdata[LO_POS +: THR_W];
        end
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[CB_AUTO_EN]  = auto_en;
            reg_rdata[CB_FC_EN]    = fc_en;
            reg_rdata[CB_MAN_ZERO] = man_zero_pend;
            reg_rdata[CB_MAN_MAX]  = man_max_pend;
            reg_rdata[CB_RX_SEEN]  = rx_seen;
            reg_rdata[CB_RX_LIVE]  = rx_pause_active;
        end else begin
            reg_rdata[THR_W-1:0]       = hi_thr;
            reg_rdata[LO_POS +: THR_W] = lo_thr;
        end
    end
endmodule

// File: rtl/pwm_req_seq.sv
// Module pwm_req_seq
// Holds the single outstanding pause request and the watermark hysteresis state.
// Order of service: manual max, manual zero, automatic. Assumes pause_ack is
// only meaningful while pause_req is high.
module pwm_req_seq
    import pwm_pkg::*;
#(
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              man_max_pend,
    input  logic              man_zero_pend,
    input  logic              below_hi,
    input  logic              above_lo,
    input  logic              pause_ack,
    output logic              pause_req,
    output logic [TIME_W-1:0] pause_time,
    output logic              done_man_max,
    output logic              done_man_zero
);
    logic      req_q;
    req_src_t  src_q;
    wm_state_t wm_q;
    logic      issue;
    req_src_t  issue_src;
    logic      acked;

    // Choose the next request when the slot is free
    always_comb begin
        issue     = 1'b0;
        issue_src = SRC_MAN_MAX;
        if (!req_q) begin
            if (man_max_pend) begin
                issue = 1'b1; issue_src = SRC_MAN_MAX;
            end else if (man_zero_pend) begin
                issue = 1'b1; issue_src = SRC_MAN_ZERO;
            end else if (auto_en && wm_q == WM_WATCH && below_hi) begin
                issue = 1'b1; issue_src = SRC_AUTO_MAX;
            end else if (auto_en && wm_q == WM_ARMED && above_lo) begin
                issue = 1'b1; issue_src = SRC_AUTO_ZERO;
            end
        end
    end

    // Completion of the held request
    always_comb begin
        acked         = req_q && pause_ack;
        done_man_max  = acked && src_q == SRC_MAN_MAX;
        done_man_zero = acked && src_q == SRC_MAN_ZERO;
    end

    // Request slot: load on issue, release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            src_q <= SRC_MAN_MAX;
        end else if (acked) begin
            req_q <= 1'b0;
        end else if (issue) begin
            req_q <= 1'b1;
            src_q <= issue_src;
        end
    end

    // Hysteresis: arm after an automatic max, disarm after the release
    always_ff @(posedge clk) begin
        if (!rst_n)
            wm_q <= WM_WATCH;
        else if (acked && src_q == SRC_AUTO_MAX)
            wm_q <= WM_ARMED;
        else if (acked && src_q == SRC_AUTO_ZERO)
            wm_q <= WM_WATCH;
    end

    // Drive the transmitter-facing request
    always_comb begin
        pause_req  = req_q;
        pause_time = (src_q == SRC_MAN_MAX || src_q == SRC_AUTO_MAX) ? '1 : '0;
        if (!req_q) pause_time = '0;
    end
endmodule

// File: rtl/pause_wm_ctrl.sv
// Module pause_wm_ctrl
// Top of the watermark pause frame flow controller: registers, two threshold
// comparators and the request sequencer. Assumes free_bytes is synchronous to
// clk and that the transmitter acknowledges each request exactly once.
module pause_wm_ctrl #(
    parameter int unsigned FREE_W    = 15,
    parameter int unsigned THR_W     = 4,
    parameter int unsigned UNIT_LOG2 = 10,
    parameter int unsigned TIME_W    = 16,
    parameter int unsigned HI_DEF    = 3,
    parameter int unsigned LO_DEF    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              pause_req,
    output logic [TIME_W-1:0] pause_time,
    input  logic              pause_ack,
    input  logic              rx_pause_rcvd,
    input  logic              rx_pause_active,
    output logic              tx_hold
);
    logic             auto_en, fc_en, man_max_pend, man_zero_pend;
    logic [THR_W-1:0] hi_thr, lo_thr;
    logic             below_hi, above_lo;
    logic             done_man_max, done_man_zero;

    pwm_regs #(
        .THR_W (THR_W),
        .HI_DEF(HI_DEF),
        .LO_DEF(LO_DEF)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_sel        (reg_sel),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .done_man_max   (done_man_max),
        .done_man_zero  (done_man_zero),
        .rx_pause_rcvd  (rx_pause_rcvd),
        .rx_pause_active(rx_pause_active),
        .auto_en        (auto_en),
        .fc_en          (fc_en),
        .man_max_pend   (man_max_pend),
        .man_zero_pend  (man_zero_pend),
        .hi_thr         (hi_thr),
        .lo_thr         (lo_thr)
    );

    pwm_thr_cmp #(
        .FREE_W(FREE_W), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2), .ABOVE(1'b0)
    ) u_cmp_hi (
        .count(free_bytes),
        .thr  (hi_thr),
        .hit  (below_hi)
    );

    pwm_thr_cmp #(
        .FREE_W(FREE_W), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2), .ABOVE(1'b1)
    ) u_cmp_lo (
        .count(free_bytes),
        .thr  (lo_thr),
        .hit  (above_lo)
    );

    pwm_req_seq #(
        .TIME_W(TIME_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_en),
        .man_max_pend (man_max_pend),
        .man_zero_pend(man_zero_pend),
        .below_hi     (below_hi),
        .above_lo     (above_lo),
        .pause_ack    (pause_ack),
        .pause_req    (pause_req),
        .pause_time   (pause_time),
        .done_man_max (done_man_max),
        .done_man_zero(done_man_zero)
    );

    // Received pause stops the local transmitter when enabled
    always_comb tx_hold = fc_en && rx_pause_active;
endmodule

// File: rtl/pwm_chk.sv
// Module pwm_chk
// Protocol checks on the request handshake and the transmit hold output.
module pwm_chk #(
    parameter int unsigned TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pause_req,
    input logic              pause_ack,
    input logic [TIME_W-1:0] pause_time,
    input logic              tx_hold,
    input logic              rx_pause_active
);
    // R1: no request on the first cycle out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !pause_req);

    // R6: an unacknowledged request stays up with the same time
    a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> pause_req && $stable(pause_time));

    // R6: an acknowledged request drops on the next cycle
    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack |=> !pause_req);

    // R7: only the two pause time codes are ever requested
    a_r7_time_codes: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (pause_time == '0 || pause_time == '1));

    // R9: the transmitter is held only while a received pause is live
    a_r9_hold_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |-> rx_pause_active);
endmodule

bind pause_wm_ctrl pwm_chk #(.TIME_W(TIME_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_req      (pause_req),
    .pause_ack      (pause_ack),
    .pause_time     (pause_time),
    .tx_hold        (tx_hold),
    .rx_pause_active(rx_pause_active)
);

// File: tb/sim_pause_wm_ctrl.sv
`timescale 1ns/1ps
module sim_pause_wm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] free_bytes = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        pause_req;
    logic [15:0] pause_time;
    logic        pause_ack = 1'b0;
    logic        rx_pause_rcvd = 1'b0, rx_pause_active = 1'b0;
    logic        tx_hold;
    int          total = 0, bad = 0;
    logic [7:0]  rv;

    pause_wm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pause_req(pause_req), .pause_time(pause_time), .pause_ack(pause_ack),
        .rx_pause_rcvd(rx_pause_rcvd), .rx_pause_active(rx_pause_active),
        .tx_hold(tx_hold)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_rd = 1'b1; reg_sel = sel;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic ack();
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
    endtask

    task automatic chk_req(input logic exp_req, input logic [15:0] exp_t, input string req);
        check(pause_req == exp_req, req, pause_req, exp_req);
        if (exp_req) check(pause_time == exp_t, req, pause_time, exp_t);
    endtask

    task automatic t_reset();
        chk_req(1'b0, 16'h0, "R1 req");
        rd(1'b0, rv); check(rv == 8'h00, "R1 ctrl", rv, 8'h00);
        rd(1'b1, rv); check(rv == 8'h83, "R1 thr", rv, 8'h83);
    endtask

    task automatic t_disabled();
        free_bytes = 15'd1000;
        repeat (3) tick();
        chk_req(1'b0, 16'h0, "R4 auto off");
        wr(1'b0, 8'h00);
    endtask

    task automatic t_no_release_first();
        free_bytes = 15'd9000;
        wr(1'b0, 8'h01);
        repeat (3) tick();
        chk_req(1'b0, 16'h0, "R3 no zero before max");
    endtask

    task automatic t_auto_cycle();
        free_bytes = 15'd3072;
        repeat (2) tick();
        chk_req(1'b0, 16'h0, "R2 equal to high mark");
        free_bytes = 15'd3071;
        tick();
        chk_req(1'b1, 16'hFFFF, "R2 max request");
        repeat (3) tick();
        chk_req(1'b1, 16'hFFFF, "R6 held until ack");
        ack();
        chk_req(1'b0, 16'h0, "R6 drop after ack");
        free_bytes = 15'd5000;
        repeat (3) tick();
        chk_req(1'b0, 16'h0, "R3 between marks");
        free_bytes = 15'd8192;
        repeat (2) tick();
        chk_req(1'b0, 16'h0, "R3 equal to low mark");
        free_bytes = 15'd8193;
        tick();
        chk_req(1'b1, 16'h0000, "R3 release request");
        ack();
        repeat (3) tick();
        chk_req(1'b0, 16'h0, "R3 single release");
        free_bytes = 15'd100;
        tick();
        chk_req(1'b1, 16'hFFFF, "R10 rearmed max");
        ack();
        free_bytes = 15'd9000;
        tick();
        chk_req(1'b1, 16'h0000, "R10 second release");
        ack();
    endtask

    task automatic t_zero_thresh();
        wr(1'b1, 8'h80);
        free_bytes = 15'd0;
        repeat (3) tick();
        chk_req(1'b0, 16'h0, "R5 zero high mark");
        wr(1'b1, 8'h83);
        tick();
        chk_req(1'b1, 16'hFFFF, "R5 restored mark fires");
        ack();
        free_bytes = 15'd9000;
        tick();
        ack();
        wr(1'b0, 8'h00);
    endtask

    task automatic t_manual();
        wr(1'b0, 8'h04);
        tick();
        chk_req(1'b1, 16'h0000, "R7 manual zero");
        wr(1'b0, 8'h00);
        rd(1'b0, rv); check(rv[2] == 1'b1, "R7 write 0 ignored", rv[2], 1);
        ack();
        chk_req(1'b0, 16'h0, "R7 manual zero done");
        rd(1'b0, rv); check(rv[2] == 1'b0, "R7 zero bit cleared", rv[2], 0);
        wr(1'b0, 8'h08);
        tick();
        chk_req(1'b1, 16'hFFFF, "R7 manual max");
        ack();
        rd(1'b0, rv); check(rv[3] == 1'b0, "R7 max bit cleared", rv[3], 0);
        chk_req(1'b0, 16'h0, "R7 no manual left");
    endtask

    task automatic t_priority();
        free_bytes = 15'd500;
        wr(1'b0, 8'h0D);
        tick();
        chk_req(1'b1, 16'hFFFF, "R8 manual max first");
        rd(1'b0, rv); check(rv[3:2] == 2'b11, "R8 both pending", rv[3:2], 3);
        ack();
        chk_req(1'b0, 16'h0, "R8 gap after ack");
        tick();
        chk_req(1'b1, 16'h0000, "R8 manual zero second");
        ack();
        tick();
        chk_req(1'b1, 16'hFFFF, "R8 automatic last");
        ack();
        free_bytes = 15'd9000;
        tick();
        chk_req(1'b1, 16'h0000, "R3 release after auto");
        ack();
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx();
        wr(1'b0, 8'h02);
        rx_pause_active = 1'b1;
        #1 check(tx_hold == 1'b1, "R9 hold on", tx_hold, 1);
        rx_pause_rcvd = 1'b1;
        tick();
        rx_pause_rcvd = 1'b0;
        rd(1'b0, rv); check(rv[5:4] == 2'b11, "R9 seen and live", rv[5:4], 3);
        rd(1'b0, rv); check(rv[4] == 1'b0, "R9 clear on read", rv[4], 0);
        rx_pause_active = 1'b0;
        #1 check(tx_hold == 1'b0, "R9 hold off", tx_hold, 0);
        wr(1'b0, 8'h00);
        rx_pause_active = 1'b1;
        #1 check(tx_hold == 1'b0, "R9 fc disabled", tx_hold, 0);
        rx_pause_active = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_no_release_first();
        t_auto_cycle();
        t_zero_thresh();
        t_manual();
        t_priority();
        t_rx();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule